// File: doc/BRIEF.md
# Mode-Aware Branch Target Fetch Unit

This unit turns a branch reference into a branch address for a small CPU with two address-space sizes. The size is chosen by a static mode input wired from board-level pins. In compact mode the space is 64 Kbytes and addresses are 16 bits. In wide mode the space is 16 Mbytes and addresses are 24 bits. A request names one of two reference kinds. The first is an 8-bit absolute field from a memory-indirect jump or call. The second is an exception vector number. Both kinds index the same table region at the bottom of memory.

For each accepted request the unit forms the table address and reads the entry one byte at a time, high byte first, from a byte-wide synchronous memory port. It then presents the assembled target, masked to the active address width, with a one-cycle valid pulse. A separate combinational path masks ordinary effective addresses to the mode width. The fetch logic holds off new requests while `busy_o` is high.

Top module: `branch_target_unit`

## Requirements
- R1: After reset, `busy_o`, `target_valid_o` and `mem_rd_o` are low and `mem_addr_o` is zero.
- R2: Compact mode (`mode_adv_i`=0) with a vector request (`kind_i`=1) reads the two bytes at `sel_i`*2 and `sel_i`*2+1. It returns them as a 16-bit target, with the lower-address byte in bits 15:8 and bits 23:16 zero.
- R3: Compact mode with an indirect request (`kind_i`=0) reads a word at the address formed by `sel_i` with bit 0 cleared, zero-extended. Bytes are combined as in R2.
- R4: Wide mode (`mode_adv_i`=1) with a vector request reads the four bytes from `sel_i`*4 upward. The target is the last three bytes read, with the earliest of those three in bits 23:16.
- R5: Wide mode with an indirect request reads a longword at `sel_i` with bits 1:0 cleared, and forms the target as in R4.
- R6: In compact mode, `ea_o` equals `ea_i` bits 15:0 with bits 23:16 zero, and `mem_addr_o` bits 23:16 stay zero. In wide mode, `ea_o` equals `ea_i`.
- R7: The memory port returns the byte one cycle after its address is driven with `mem_rd_o` high. The unit drives consecutive byte addresses on consecutive cycles, starting in the cycle after acceptance.
- R8: With N bytes per entry (2 compact, 4 wide), `target_valid_o` is high for exactly one cycle, N+1 cycles after the accepting edge. `busy_o` is high from the cycle after acceptance until that pulse and is low during it.
- R9: A request with `busy_o` high is ignored: the address sequence and returned target are those of the accepted request.
- R10: When `mem_rd_o` is low, `mem_addr_o` is zero, and `mem_rd_o` is only high while `busy_o` is high.
- R11: `target_o` holds its value after the valid pulse until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_adv_i | input | 1 | Static mode: 0 compact 16-bit, 1 wide 24-bit |
| req_i | input | 1 | Start a target fetch |
| kind_i | input | 1 | 0 indirect-branch field, 1 vector number |
| sel_i | input | 8 | Absolute field or vector number |
| busy_o | output | 1 | Fetch in progress |
| target_valid_o | output | 1 | One-cycle pulse, target ready |
| target_o | output | 24 | Branch target masked to mode width |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 24 | Byte address to memory |
| mem_rdata_i | input | 8 | Read byte, one cycle after address |
| ea_i | input | 24 | Raw effective address |
| ea_o | output | 24 | Effective address masked to mode width |

## Verification
The assertions assume the mode input never changes while a fetch is in flight. They also assume the memory answers with exactly one cycle of latency. The stimulus changes the mode only between fetches, after `busy_o` has dropped. It models the memory as a register clocked from the driven address, so both assumptions hold throughout. Requests made while busy are deliberately injected, to show that they leave the address walk and the target untouched.

// File: rtl/btu_pkg.sv
package btu_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WIDE_BYTES = 4;
  localparam int unsigned NARROW_BYTES = 2;

  typedef enum logic {
    KIND_INDIRECT = 1'b0,
    KIND_VECTOR   = 1'b1
  } ref_kind_e;
endpackage

// File: rtl/btu_addr_gen.sv
module btu_addr_gen
  import btu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NW = NARROW_W,
  parameter int unsigned SW = 8,
  parameter int unsigned CW = 3
) (
  input  logic          mode_adv_i,
  input  ref_kind_e     kind_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] ea_i,
  output logic [AW-1:0] base_o,
  output logic [CW-1:0] nbytes_o,
  output logic [AW-1:0] ea_o
);
  localparam logic [CW-1:0] NB_WIDE   = CW'(WIDE_BYTES);
  localparam logic [CW-1:0] NB_NARROW = CW'(NARROW_BYTES);

  logic [AW-1:0] sel_ext;
  assign sel_ext = AW'(sel_i);

  always_comb begin
    base_o = '0;
    unique case ({mode_adv_i, kind_i})
      {1'b0, KIND_VECTOR}:   base_o = sel_ext << 1;
      {1'b0, KIND_INDIRECT}: base_o = {sel_ext[AW-1:1], 1'b0};
      {1'b1, KIND_VECTOR}:   base_o = sel_ext << 2;
      {1'b1, KIND_INDIRECT}: base_o = {sel_ext[AW-1:2], 2'b00};
      default:               base_o = '0;
    endcase
    nbytes_o = mode_adv_i ? NB_WIDE : NB_NARROW;
  end

  // effective-address width clamp
  always_comb begin
    ea_o = ea_i;
    if (!mode_adv_i) ea_o[AW-1:NW] = '0;
  end
endmodule

// File: rtl/btu_fetch_seq.sv
module btu_fetch_seq
  import btu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          mode_adv_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] nbytes_i,
  output logic          accept_o,
  output logic          cap_en_o,
  output logic          mode_q_o,
  output logic          busy_o,
  output logic          valid_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o
);
  logic          busy_q, valid_q, rd_q, rdv_q, mode_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] issued_q, capt_q, nb_q;

  assign accept_o = req_i & ~busy_q;
  assign cap_en_o = busy_q & rdv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      valid_q  <= 1'b0;
      rd_q     <= 1'b0;
      rdv_q    <= 1'b0;
      mode_q   <= 1'b0;
      addr_q   <= '0;
      issued_q <= '0;
      capt_q   <= '0;
      nb_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      rdv_q   <= rd_q;
      if (accept_o) begin
        busy_q   <= 1'b1;
        rd_q     <= 1'b1;
        addr_q   <= base_i;
        issued_q <= CW'(1);
        capt_q   <= '0;
        nb_q     <= nbytes_i;
        mode_q   <= mode_adv_i;
      end else if (busy_q) begin
        if (rd_q) begin
          if (issued_q == nb_q) begin
            rd_q   <= 1'b0;
            addr_q <= '0;
          end else begin
            addr_q   <= addr_q + AW'(1);
            issued_q <= issued_q + CW'(1);
          end
        end
        if (rdv_q) begin
          capt_q <= capt_q + CW'(1);
          if (capt_q + CW'(1) == nb_q) begin
            busy_q  <= 1'b0;
            valid_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign valid_o    = valid_q;
  assign mem_rd_o   = rd_q;
  assign mem_addr_o = addr_q;
  assign mode_q_o   = mode_q;
endmodule

// File: rtl/btu_target_asm.sv
module btu_target_asm
  import btu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NW = NARROW_W,
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cap_en_i,
  input  logic          mode_adv_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] target_o
);
  // earlier bytes shift toward the top; overflow of a longword drops its high byte
  logic [AW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clr_i)    acc_q <= '0;
    else if (cap_en_i) acc_q <= {acc_q[AW-DW-1:0], rdata_i};
  end

  always_comb begin
    target_o = acc_q;
    if (!mode_adv_i) target_o[AW-1:NW] = '0;
  end
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import btu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NW = NARROW_W,
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_adv_i,
  input  logic          req_i,
  input  logic          kind_i,
  input  logic [SW-1:0] sel_i,
  output logic          busy_o,
  output logic          target_valid_o,
  output logic [AW-1:0] target_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [AW-1:0] ea_i,
  output logic [AW-1:0] ea_o
);
  localparam int unsigned CW = $clog2(WIDE_BYTES + 1);

  logic [AW-1:0] base;
  logic [CW-1:0] nbytes;
  logic          accept, cap_en, mode_q;
  ref_kind_e     kind;

  assign kind = ref_kind_e'(kind_i);

  btu_addr_gen #(.AW(AW), .NW(NW), .SW(SW), .CW(CW)) addr_gen_i (
    .mode_adv_i (mode_adv_i),
    .kind_i     (kind),
    .sel_i      (sel_i),
    .ea_i       (ea_i),
    .base_o     (base),
    .nbytes_o   (nbytes),
    .ea_o       (ea_o)
  );

  btu_fetch_seq #(.AW(AW), .CW(CW)) fetch_seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .mode_adv_i (mode_adv_i),
    .base_i     (base),
    .nbytes_i   (nbytes),
    .accept_o   (accept),
    .cap_en_o   (cap_en),
    .mode_q_o   (mode_q),
    .busy_o     (busy_o),
    .valid_o    (target_valid_o),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o)
  );

  btu_target_asm #(.AW(AW), .NW(NW), .DW(DW)) target_asm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .cap_en_i   (cap_en),
    .mode_adv_i (mode_q),
    .rdata_i    (mem_rdata_i),
    .target_o   (target_o)
  );
endmodule

// File: rtl/btu_chk.sv
module btu_chk #(
  parameter int unsigned AW = 24,
  parameter int unsigned NW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_adv_i,
  input logic          busy_o,
  input logic          target_valid_o,
  input logic [AW-1:0] target_o,
  input logic          mem_rd_o,
  input logic [AW-1:0] mem_addr_o
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_valid_o |=> !target_valid_o);
  // R8
  valid_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_valid_o |-> !busy_o);
  // R8
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> target_valid_o);
  // R10
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rd_o |-> mem_addr_o == '0);
  // R10
  rd_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_o);
  // R7
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_rd_o)) |-> mem_addr_o == $past(mem_addr_o) + AW'(1));
  // R7
  start_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mem_rd_o);
  // R6
  narrow_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_adv_i |-> mem_addr_o[AW-1:NW] == '0);
  // R2
  narrow_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (target_valid_o && !mode_adv_i) |-> target_o[AW-1:NW] == '0);
  // R11
  target_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(target_valid_o) |-> $stable(target_o));
endmodule

bind branch_target_unit btu_chk #(.AW(AW), .NW(NW)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_adv_i     (mode_adv_i),
  .busy_o         (busy_o),
  .target_valid_o (target_valid_o),
  .target_o       (target_o),
  .mem_rd_o       (mem_rd_o),
  .mem_addr_o     (mem_addr_o)
);

// File: tb/branch_target_unit_tb_top.sv
`timescale 1ns/1ps
module branch_target_unit_tb_top;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_adv = 1'b0, req = 1'b0, kind = 1'b0;
  logic [7:0]    sel = '0;
  logic          busy, tvalid, mem_rd;
  logic [AW-1:0] target, mem_addr, ea_in = '0, ea_out;
  logic [7:0]    mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] exp_q[$];

  always #10 clk = ~clk;

  branch_target_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_adv_i(mode_adv), .req_i(req),
    .kind_i(kind), .sel_i(sel), .busy_o(busy), .target_valid_o(tvalid),
    .target_o(target), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .ea_i(ea_in), .ea_o(ea_out)
  );

  function automatic logic [7:0] mem_fn(logic [AW-1:0] a);
    return (a[7:0] * 8'd29) ^ {a[9:8], 6'h15} ^ 8'h5A;
  endfunction

  // R7: one-cycle memory
  always_ff @(posedge clk) mem_rdata <= mem_fn(mem_addr);

  task automatic check(input string req_id, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_id, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops expected targets on every valid pulse
  always @(negedge clk) begin
    if (rst_n && tvalid) begin
      if (exp_q.size() == 0) check("R9 unexpected target", 32'(target), 32'hDEAD);
      else check("R2-5 target", 32'(target), 32'(exp_q.pop_front()));
    end
  end

  task automatic fetch(input logic adv, input logic k, input logic [7:0] s,
                       input bit probe, input string rid);
    logic [AW-1:0] base, exp_t;
    int nb;
    nb = adv ? 4 : 2;
    if (!adv) base = k ? AW'(s) << 1 : AW'({s[7:1], 1'b0});
    else      base = k ? AW'(s) << 2 : AW'({s[7:2], 2'b00});
    exp_t = '0;
    for (int i = 0; i < nb; i++) exp_t = {exp_t[AW-9:0], mem_fn(base + AW'(i))};
    if (!adv) exp_t[23:16] = '0;
    exp_q.push_back(exp_t);
    @(negedge clk);
    mode_adv = adv; kind = k; sel = s; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < nb; i++) begin
      check({rid, " R7 addr"}, 32'(mem_addr), 32'(base + AW'(i)));
      check("R10 rd", 32'(mem_rd), 1);
      check("R8 busy", 32'(busy), 1);
      if (probe && i == 0) begin
        kind = ~k; sel = ~s; req = 1'b1;
      end
      @(negedge clk);
      req = 1'b0;
    end
    check("R8 early", 32'(tvalid), 0);
    check("R10 bus idle", 32'(mem_addr), 0);
    @(negedge clk);
    check({rid, " R8 pulse"}, 32'(tvalid), 1);
    check("R8 busy low", 32'(busy), 0);
    @(negedge clk);
    check("R8 single", 32'(tvalid), 0);
    check("R11 hold", 32'(target), 32'(exp_t));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #5;
    check("R1 busy", 32'(busy), 0);
    check("R1 valid", 32'(tvalid), 0);
    check("R1 addr", 32'(mem_addr), 0);
    check("R1 rd", 32'(mem_rd), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", 32'(busy), 0);

    fetch(1'b0, 1'b1, 8'h00, 0, "R2");
    fetch(1'b0, 1'b1, 8'h05, 0, "R2");
    fetch(1'b0, 1'b1, 8'hFF, 1, "R2 R9");
    fetch(1'b0, 1'b0, 8'h37, 0, "R3");
    fetch(1'b0, 1'b0, 8'hFE, 1, "R3 R9");
    fetch(1'b1, 1'b1, 8'h00, 0, "R4");
    fetch(1'b1, 1'b1, 8'h09, 1, "R4 R9");
    fetch(1'b1, 1'b1, 8'hFF, 0, "R4");
    fetch(1'b1, 1'b0, 8'h3B, 0, "R5");
    fetch(1'b1, 1'b0, 8'hFF, 1, "R5 R9");

    mode_adv = 1'b0; ea_in = 24'hABCDEF; #1;
    check("R6 narrow ea", 32'(ea_out), 32'h00CDEF);
    mode_adv = 1'b1; #1;
    check("R6 wide ea", 32'(ea_out), 32'hABCDEF);
    ea_in = 24'h00FFFF; mode_adv = 1'b0; #1;
    check("R6 narrow ea edge", 32'(ea_out), 32'h00FFFF);

    repeat (4) @(negedge clk);
    check("R9 queue drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule